// File: doc/BRIEF.md
# Stack Transfer Sequencer

This block carries out the control-transfer and stack operations of a small 8-bit processor with a 16-bit stack pointer. It runs subroutine calls and returns, conditional or not, and restarts to one of eight fixed vectors. It also pushes and pops register pairs and swaps a register pair with the top of the stack. The surrounding core fetches the opcode, decodes it into a command, and pulses `start`. The sequencer then moves bytes one at a time over a request/acknowledge port. It builds 16-bit values from two byte transfers and tests the condition against the flag byte. When the command ends it reports a new program counter and/or a register-pair value.

The stack grows downward, and SP points at the first free byte. A push stores the high byte at SP and the low byte at SP-1, which leaves SP two lower. A pop reads SP+1 (low byte), then SP+2 (high byte). The 16-bit item on top of the stack therefore has its low byte at SP+1 and its high byte at SP+2. The condition is resolved in the first cycle. A return whose condition fails finishes at once. A call whose condition fails still reads its two operand bytes, so execution continues past the three-byte instruction.

States: `S_IDLE` (waits for `start`), `S_OPND_LO`/`S_OPND_HI` (read call operands), `S_WR_HI`/`S_WR_LO` (push two bytes), `S_RD_LO`/`S_RD_HI` (pop two bytes), `S_XRD_HI`/`S_XWR_HI`/`S_XRD_LO`/`S_XWR_LO` (exchange), and `S_END` (one-cycle completion). Transitions:
- IDLE→OPND_LO for a call.
- IDLE→RD_LO for a pop, or for a return whose condition holds. IDLE→END for a return whose condition fails.
- IDLE→WR_HI for a restart or a push.
- IDLE→XRD_HI for an exchange. IDLE→END for an unused command code.
- OPND_HI→WR_HI if the call is taken, else →END.
- WR_HI→WR_LO→END, RD_LO→RD_HI→END, and XRD_HI→XWR_HI→XRD_LO→XWR_LO→END.
- END→IDLE.
Each bus state advances only on `bus_ack`.

Top module: `stk_seq`

## Requirements
- R1: After reset the block is idle (`busy`=0, `done`=0, `bus_req`=0) and `sp` equals 16'hFFFF.
- R2: Push (`op`=3) writes `pair_in[15:8]` at SP, then `pair_in[7:0]` at SP-1, and leaves SP reduced by 2. It takes three cycles from `start` to `done` with zero-wait acknowledges.
- R3: Pop (`op`=4) reads SP+1 into `pair_out[7:0]`, then SP+2 into `pair_out[15:8]`, and raises `pair_we` with `done`. It leaves SP raised by 2. When the pair holds flags and accumulator, the first byte is the flag byte.
- R4: Call (`op`=0) reads the target low byte at `pc_next` and the high byte at `pc_next`+1. It then pushes `pc_next`+2 (high byte first) and raises `pc_load` with `pc_value` = target. It takes five cycles.
- R5: Return (`op`=1) pops a 16-bit value (low byte first) into `pc_value` with `pc_load`.
- R6: Restart (`op`=2) pushes `pc_next` and loads `pc_value` = `vec_num`×8 (0x00 to 0x38).
- R7: When `cond_en`=1, `cond_sel` picks the test. 0 is Z=0 and 1 is Z=1, with Z at flag bit 6. 2 is C=0 and 3 is C=1, with C at bit 0. 4 is P=0 and 5 is P=1, with P at bit 2. 6 is S=0 and 7 is S=1, with S at bit 7. When `cond_en`=0 the transfer is always taken.
- R8: A return whose condition fails raises `done` one cycle after `start`. It makes no bus request and gives no `pc_load`, and SP is unchanged.
- R9: A call whose condition fails reads both operand bytes and makes no write. It leaves SP unchanged and raises `pc_load` with `pc_value` = `pc_next`+2, three cycles after `start`.
- R10: Exchange (`op`=5) reads SP+2 and writes `pair_in[15:8]` there, then reads SP+1 and writes `pair_in[7:0]` there. It returns the old top item on `pair_out` with `pair_we` and leaves SP unchanged.
- R11: While `bus_req` is high and `bus_ack` is low, the request, address, direction and write data hold.
- R12: `start` is ignored while `busy`=1.
- R13: SP arithmetic wraps modulo 2^16.
- R14: `pc_load` and `pair_we` appear only together with `done`. `done` lasts one cycle and is followed by idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command (taken only when idle) |
| op | input | 3 | Command: 0 call, 1 return, 2 restart, 3 push, 4 pop, 5 exchange |
| cond_en | input | 1 | Command is conditional |
| cond_sel | input | 3 | Condition code (see R7) |
| vec_num | input | 3 | Restart vector number |
| flags | input | 8 | Flag byte |
| pc_next | input | 16 | Address of the byte after the opcode |
| pair_in | input | 16 | Register pair to push or exchange |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command complete (one cycle) |
| pc_load | output | 1 | Load `pc_value` into the program counter |
| pc_value | output | 16 | New program counter |
| pair_we | output | 1 | Write `pair_out` to the register pair |
| pair_out | output | 16 | Value for the register pair |
| sp | output | 16 | Current stack pointer |
| bus_req | output | 1 | Byte transfer request |
| bus_we | output | 1 | Transfer is a write |
| bus_addr | output | 16 | Transfer address |
| bus_wdata | output | 8 | Write byte |
| bus_ack | input | 1 | Transfer accepted this cycle |
| bus_rdata | input | 8 | Read byte, valid with `bus_ack` |

## Verification
The assertions assume that `bus_ack` is high only while `bus_req` is high and that `bus_rdata` is valid in the acknowledge cycle. They also assume `op` holds one of the six defined codes when `start` is high. The bench meets these conditions by deriving `bus_ack` from `bus_req`, gated only by a bench-controlled stall. Read data comes from a byte array indexed by the low address byte, and writes are committed on the acknowledging edge. The bench drives only defined command codes. It also keeps the stack and operand addresses apart in that array, so that every value it expects follows from the requirements alone.

// File: rtl/stk_pkg.sv
package stk_pkg;
    typedef enum logic [2:0] {
        OP_CALL = 3'd0,
        OP_RET  = 3'd1,
        OP_RST  = 3'd2,
        OP_PUSH = 3'd3,
        OP_POP  = 3'd4,
        OP_XCHG = 3'd5
    } stk_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_OPND_LO,
        S_OPND_HI,
        S_WR_HI,
        S_WR_LO,
        S_RD_LO,
        S_RD_HI,
        S_XRD_HI,
        S_XWR_HI,
        S_XRD_LO,
        S_XWR_LO,
        S_END
    } stk_state_e;

    // flag bit positions tested by the condition codes
    localparam int FLG_C = 0;
    localparam int FLG_P = 2;
    localparam int FLG_Z = 6;
    localparam int FLG_S = 7;
endpackage

// File: rtl/stk_cond_eval.sv
module stk_cond_eval
    import stk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] flags,
    input  logic              cond_en,
    input  logic [2:0]        cond_sel,
    output logic              taken
);
    localparam int NUM_TESTS = 4;
    localparam int IDX_W     = $clog2(DATA_W);

    logic [IDX_W-1:0] bit_idx [NUM_TESTS];

    // one tested flag per condition pair; cond_sel[0] picks polarity
    generate
        for (genvar g = 0; g < NUM_TESTS; g++) begin : g_map
            localparam int POS = (g == 0) ? FLG_Z :
                                 (g == 1) ? FLG_C :
                                 (g == 2) ? FLG_P : FLG_S;
            assign bit_idx[g] = IDX_W'(POS);
        end
    endgenerate

    logic tested;
    assign tested = flags[bit_idx[cond_sel[2:1]]];
    assign taken  = !cond_en || (cond_sel[0] ? tested : !tested);
endmodule

// File: rtl/stk_vector_gen.sv
module stk_vector_gen #(
    parameter int ADDR_W   = 16,
    parameter int VEC_BITS = 3,
    parameter int STRIDE   = 8
) (
    input  logic [VEC_BITS-1:0] vec_num,
    output logic [ADDR_W-1:0]   vec_addr
);
    localparam int SHIFT = $clog2(STRIDE);

    generate
        if ((1 << SHIFT) == STRIDE) begin : g_pow2
            assign vec_addr = ADDR_W'(vec_num) << SHIFT;
        end else begin : g_mul
            assign vec_addr = ADDR_W'(vec_num) * ADDR_W'(STRIDE);
        end
    endgenerate
endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
#(
    parameter int          DATA_W   = 8,
    parameter int          VEC_BITS = 3,
    parameter int          STRIDE   = 8,
    parameter logic [15:0] SP_INIT  = 16'hFFFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [2:0]            op,
    input  logic                  cond_en,
    input  logic [2:0]            cond_sel,
    input  logic [VEC_BITS-1:0]   vec_num,
    input  logic [DATA_W-1:0]     flags,
    input  logic [2*DATA_W-1:0]   pc_next,
    input  logic [2*DATA_W-1:0]   pair_in,
    output logic                  busy,
    output logic                  done,
    output logic                  pc_load,
    output logic [2*DATA_W-1:0]   pc_value,
    output logic                  pair_we,
    output logic [2*DATA_W-1:0]   pair_out,
    output logic [2*DATA_W-1:0]   sp,
    output logic                  bus_req,
    output logic                  bus_we,
    output logic [2*DATA_W-1:0]   bus_addr,
    output logic [DATA_W-1:0]     bus_wdata,
    input  logic                  bus_ack,
    input  logic [DATA_W-1:0]     bus_rdata
);
    localparam int ADDR_W = 2 * DATA_W;

    stk_state_e        state_q, state_d;
    stk_op_e           op_q;
    logic [ADDR_W-1:0] sp_q, base_q, tgt_q, wval_q, rbuf_q;
    logic              jump_q, pcl_q;
    logic              taken, xfer;
    logic [ADDR_W-1:0] vec_addr;
    stk_op_e           op_in;

    assign op_in = stk_op_e'(op);
    assign xfer  = bus_req && bus_ack;

    stk_cond_eval #(.DATA_W(DATA_W)) u_cond (
        .flags    (flags),
        .cond_en  (cond_en),
        .cond_sel (cond_sel),
        .taken    (taken)
    );

    stk_vector_gen #(.ADDR_W(ADDR_W), .VEC_BITS(VEC_BITS), .STRIDE(STRIDE)) u_vec (
        .vec_num  (vec_num),
        .vec_addr (vec_addr)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) begin
                unique case (op_in)
                    OP_CALL: state_d = S_OPND_LO;
                    OP_RET:  state_d = taken ? S_RD_LO : S_END;
                    OP_RST,
                    OP_PUSH: state_d = S_WR_HI;
                    OP_POP:  state_d = S_RD_LO;
                    OP_XCHG: state_d = S_XRD_HI;
                    default: state_d = S_END;
                endcase
            end
            S_OPND_LO: if (bus_ack) state_d = S_OPND_HI;
            S_OPND_HI: if (bus_ack) state_d = jump_q ? S_WR_HI : S_END;
            S_WR_HI:   if (bus_ack) state_d = S_WR_LO;
            S_WR_LO:   if (bus_ack) state_d = S_END;
            S_RD_LO:   if (bus_ack) state_d = S_RD_HI;
            S_RD_HI:   if (bus_ack) state_d = S_END;
            S_XRD_HI:  if (bus_ack) state_d = S_XWR_HI;
            S_XWR_HI:  if (bus_ack) state_d = S_XRD_LO;
            S_XRD_LO:  if (bus_ack) state_d = S_XWR_LO;
            S_XWR_LO:  if (bus_ack) state_d = S_END;
            S_END:     state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q   <= SP_INIT;
            op_q   <= OP_CALL;
            base_q <= '0;
            tgt_q  <= '0;
            wval_q <= '0;
            rbuf_q <= '0;
            jump_q <= 1'b0;
            pcl_q  <= 1'b0;
        end else begin
            if (state_q == S_IDLE && start) begin
                op_q   <= op_in;
                base_q <= pc_next;
                jump_q <= taken;
                pcl_q  <= (op_in == OP_CALL) || (op_in == OP_RST) ||
                          (op_in == OP_RET && taken);
                wval_q <= (op_in == OP_RST) ? pc_next : pair_in;
                tgt_q  <= vec_addr;
            end
            if (xfer) begin
                unique case (state_q)
                    S_OPND_LO: rbuf_q[DATA_W-1:0] <= bus_rdata;
                    S_OPND_HI: begin
                        wval_q <= base_q + ADDR_W'(2);
                        tgt_q  <= jump_q ? {bus_rdata, rbuf_q[DATA_W-1:0]}
                                         : base_q + ADDR_W'(2);
                    end
                    S_WR_HI, S_WR_LO: sp_q <= sp_q - ADDR_W'(1);
                    S_RD_LO: begin
                        sp_q <= sp_q + ADDR_W'(1);
                        rbuf_q[DATA_W-1:0] <= bus_rdata;
                    end
                    S_RD_HI: begin
                        sp_q <= sp_q + ADDR_W'(1);
                        rbuf_q[ADDR_W-1:DATA_W] <= bus_rdata;
                        tgt_q <= {bus_rdata, rbuf_q[DATA_W-1:0]};
                    end
                    S_XRD_HI: rbuf_q[ADDR_W-1:DATA_W] <= bus_rdata;
                    S_XRD_LO: rbuf_q[DATA_W-1:0]      <= bus_rdata;
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = sp_q;
        bus_wdata = '0;
        unique case (state_q)
            S_OPND_LO: begin bus_req = 1'b1; bus_addr = base_q; end
            S_OPND_HI: begin bus_req = 1'b1; bus_addr = base_q + ADDR_W'(1); end
            S_WR_HI: begin
                bus_req = 1'b1; bus_we = 1'b1; bus_wdata = wval_q[ADDR_W-1:DATA_W];
            end
            S_WR_LO: begin
                bus_req = 1'b1; bus_we = 1'b1; bus_wdata = wval_q[DATA_W-1:0];
            end
            S_RD_LO, S_RD_HI: begin bus_req = 1'b1; bus_addr = sp_q + ADDR_W'(1); end
            S_XRD_HI: begin bus_req = 1'b1; bus_addr = sp_q + ADDR_W'(2); end
            S_XWR_HI: begin
                bus_req = 1'b1; bus_we = 1'b1; bus_addr = sp_q + ADDR_W'(2);
                bus_wdata = wval_q[ADDR_W-1:DATA_W];
            end
            S_XRD_LO: begin bus_req = 1'b1; bus_addr = sp_q + ADDR_W'(1); end
            S_XWR_LO: begin
                bus_req = 1'b1; bus_we = 1'b1; bus_addr = sp_q + ADDR_W'(1);
                bus_wdata = wval_q[DATA_W-1:0];
            end
            default: ;
        endcase
    end

    assign busy     = (state_q != S_IDLE);
    assign done     = (state_q == S_END);
    assign pc_load  = done && pcl_q;
    assign pc_value = tgt_q;
    assign pair_we  = done && (op_q == OP_POP || op_q == OP_XCHG);
    assign pair_out = rbuf_q;
    assign sp       = sp_q;

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) &&
                                   $stable(bus_we) && $stable(bus_wdata)));

    // R14
    pc_load_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> done);

    // R14
    pair_we_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !pair_we));

    // R2
    sp_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && (state_q == S_WR_HI || state_q == S_WR_LO)) |=>
            (sp_q == $past(sp_q) - ADDR_W'(1)));

    // R3
    sp_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && (state_q == S_RD_LO || state_q == S_RD_HI)) |=>
            (sp_q == $past(sp_q) + ADDR_W'(1)));

    // R8
    ret_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start && op_in == OP_RET && !taken) |=>
            (done && !bus_req && !pc_load));

    // R12
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !bus_ack) |=> busy);
endmodule

// File: tb/test_stk_seq.sv
module test_stk_seq;
    typedef struct packed {
        logic [2:0]  op;
        logic        ce;
        logic [2:0]  cs;
        logic [2:0]  vn;
        logic [7:0]  fl;
        logic [15:0] pcn;
        logic [15:0] pin;
        logic        pcl;
        logic [15:0] pcv;
        logic        pwe;
        logic [15:0] pv;
        logic [15:0] spx;
        logic [3:0]  cyc;
        logic [1:0]  wc;
        logic [7:0]  ma;
        logic [7:0]  md;
        logic [7:0]  tag;
    } vec_t;

    localparam int NV = 17;
    // op,ce,cs,vn,flags,pc_next,pair_in, pcl,pcv, pwe,pv, sp,cyc,writes, memaddr,memdata, req
    localparam vec_t TBL [NV] = '{
        '{3'd3,1'b0,3'd0,3'd0,8'h00,16'h0000,16'hBEEF,1'b0,16'h0000,1'b0,16'h0000,16'hFFFD,4'd3,2'd2,8'hFF,8'hBE,8'd2},  // R2 push
        '{3'd4,1'b0,3'd0,3'd0,8'h00,16'h0000,16'h0000,1'b0,16'h0000,1'b1,16'hBEEF,16'hFFFF,4'd3,2'd0,8'hFE,8'hEF,8'd3},  // R3 pop
        '{3'd0,1'b0,3'd0,3'd0,8'h00,16'h0040,16'h0000,1'b1,16'h1234,1'b0,16'h0000,16'hFFFD,4'd5,2'd2,8'hFE,8'h42,8'd4},  // R4 call
        '{3'd1,1'b0,3'd0,3'd0,8'h00,16'h0000,16'h0000,1'b1,16'h0042,1'b0,16'h0000,16'hFFFF,4'd3,2'd0,8'hFF,8'h00,8'd5},  // R5 ret
        '{3'd1,1'b1,3'd1,3'd0,8'h00,16'h0000,16'h0000,1'b0,16'h0000,1'b0,16'h0000,16'hFFFF,4'd1,2'd0,8'hFF,8'h00,8'd8},  // R8 ret Z false
        '{3'd2,1'b0,3'd0,3'd5,8'h00,16'h0100,16'h0000,1'b1,16'h0028,1'b0,16'h0000,16'hFFFD,4'd3,2'd2,8'hFF,8'h01,8'd6},  // R6 vector 5
        '{3'd5,1'b0,3'd0,3'd0,8'h00,16'h0000,16'h5566,1'b0,16'h0000,1'b1,16'h0100,16'hFFFD,4'd5,2'd2,8'hFF,8'h55,8'd10}, // R10 exchange
        '{3'd1,1'b1,3'd3,3'd0,8'h01,16'h0000,16'h0000,1'b1,16'h5566,1'b0,16'h0000,16'hFFFF,4'd3,2'd0,8'hFE,8'h66,8'd7},  // R7 ret C taken
        '{3'd0,1'b1,3'd0,3'd0,8'h40,16'h0040,16'h0000,1'b1,16'h0042,1'b0,16'h0000,16'hFFFF,4'd3,2'd0,8'hFF,8'h55,8'd9},  // R9 call NZ false
        '{3'd0,1'b1,3'd5,3'd0,8'h04,16'h0040,16'h0000,1'b1,16'h1234,1'b0,16'h0000,16'hFFFD,4'd5,2'd2,8'hFF,8'h00,8'd7},  // R7 call PE taken
        '{3'd1,1'b1,3'd7,3'd0,8'h80,16'h0000,16'h0000,1'b1,16'h0042,1'b0,16'h0000,16'hFFFF,4'd3,2'd0,8'hFE,8'h42,8'd7},  // R7 ret M taken
        '{3'd1,1'b1,3'd6,3'd0,8'h80,16'h0000,16'h0000,1'b0,16'h0000,1'b0,16'h0000,16'hFFFF,4'd1,2'd0,8'hFE,8'h42,8'd8},  // R8 ret P false
        '{3'd3,1'b0,3'd0,3'd0,8'h00,16'h0000,16'h77C5,1'b0,16'h0000,1'b0,16'h0000,16'hFFFD,4'd3,2'd2,8'hFE,8'hC5,8'd2},  // R2 push flags pair
        '{3'd4,1'b0,3'd0,3'd0,8'h00,16'h0000,16'h0000,1'b0,16'h0000,1'b1,16'h77C5,16'hFFFF,4'd3,2'd0,8'hFF,8'h77,8'd3},  // R3 flags byte low
        '{3'd2,1'b0,3'd0,3'd7,8'h00,16'h0200,16'h0000,1'b1,16'h0038,1'b0,16'h0000,16'hFFFD,4'd3,2'd2,8'hFF,8'h02,8'd6},  // R6 vector 7
        '{3'd1,1'b1,3'd4,3'd0,8'h00,16'h0000,16'h0000,1'b1,16'h0200,1'b0,16'h0000,16'hFFFF,4'd3,2'd0,8'hFE,8'h00,8'd7},  // R7 ret PO taken
        '{3'd1,1'b1,3'd2,3'd0,8'h01,16'h0000,16'h0000,1'b0,16'h0000,1'b0,16'h0000,16'hFFFF,4'd1,2'd0,8'hFE,8'h00,8'd8}   // R8 ret NC false
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0, cond_sel = '0, vec_num = '0;
    logic        cond_en = 1'b0;
    logic [7:0]  flags = '0;
    logic [15:0] pc_next = '0, pair_in = '0;
    logic        busy, done, pc_load, pair_we, bus_req, bus_we, bus_ack;
    logic [15:0] pc_value, pair_out, sp, bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic        stall = 1'b0;
    logic [7:0]  mem [256];
    int          wr_total = 0;
    int          n_chk = 0, n_fail = 0, cycles = 0;

    always #4 clk = ~clk;

    assign bus_ack   = bus_req && !stall;
    assign bus_rdata = mem[bus_addr[7:0]];

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (bus_req && bus_ack && bus_we) begin
            mem[bus_addr[7:0]] <= bus_wdata;
            wr_total <= wr_total + 1;
        end
    end

    stk_seq i_stk_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cond_en(cond_en),
        .cond_sel(cond_sel), .vec_num(vec_num), .flags(flags), .pc_next(pc_next),
        .pair_in(pair_in), .busy(busy), .done(done), .pc_load(pc_load),
        .pc_value(pc_value), .pair_we(pair_we), .pair_out(pair_out), .sp(sp),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 1;
        while (!done && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R14 done never raised actual=0 expected=1");
        end
    endtask

    task automatic launch(input logic [2:0] o, input logic ce, input logic [2:0] cs,
                          input logic [2:0] vn, input logic [7:0] fl,
                          input logic [15:0] pcn, input logic [15:0] pin, output int cyc);
        @(negedge clk);
        op = o; cond_en = ce; cond_sel = cs; vec_num = vn; flags = fl;
        pc_next = pcn; pair_in = pin; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(cyc);
    endtask

    always @(negedge clk) begin
        if (cycles > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
            finish_run();
        end
    end

    initial begin
        int cyc, w0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        mem[8'h40] = 8'h34; mem[8'h41] = 8'h12;
        mem[8'h00] = 8'h11; mem[8'h01] = 8'h22;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 bus_req", 32'(bus_req), 32'd0);
        chk("R1 sp", 32'(sp), 32'hFFFF);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            w0 = wr_total;
            launch(TBL[v].op, TBL[v].ce, TBL[v].cs, TBL[v].vn, TBL[v].fl,
                   TBL[v].pcn, TBL[v].pin, cyc);
            chk($sformatf("R%0d v%0d cycles", TBL[v].tag, v), 32'(cyc), 32'(TBL[v].cyc));
            chk($sformatf("R%0d v%0d pc_load", TBL[v].tag, v), 32'(pc_load), 32'(TBL[v].pcl));
            if (TBL[v].pcl)
                chk($sformatf("R%0d v%0d pc_value", TBL[v].tag, v), 32'(pc_value), 32'(TBL[v].pcv));
            chk($sformatf("R%0d v%0d pair_we", TBL[v].tag, v), 32'(pair_we), 32'(TBL[v].pwe));
            if (TBL[v].pwe)
                chk($sformatf("R%0d v%0d pair_out", TBL[v].tag, v), 32'(pair_out), 32'(TBL[v].pv));
            chk($sformatf("R%0d v%0d sp", TBL[v].tag, v), 32'(sp), 32'(TBL[v].spx));
            chk($sformatf("R%0d v%0d writes", TBL[v].tag, v), 32'(wr_total - w0), 32'(TBL[v].wc));
            chk($sformatf("R%0d v%0d mem", TBL[v].tag, v), 32'(mem[TBL[v].ma]), 32'(TBL[v].md));
        end

        // R13 pop from SP=FFFF wraps to addresses 0000/0001
        launch(3'd4, 1'b0, 3'd0, 3'd0, 8'h00, 16'h0000, 16'h0000, cyc);
        chk("R13 pop wrap pair_out", 32'(pair_out), 32'h2211);
        chk("R13 pop wrap sp", 32'(sp), 32'h0001);
        // R13 push back across the wrap
        launch(3'd3, 1'b0, 3'd0, 3'd0, 8'h00, 16'h0000, 16'hA1B2, cyc);
        chk("R13 push wrap sp", 32'(sp), 32'hFFFF);
        chk("R13 push wrap hi byte", 32'(mem[8'h01]), 32'hA1);
        chk("R13 push wrap lo byte", 32'(mem[8'h00]), 32'hB2);

        // R11 and R12: stalled call with a second start while busy
        w0 = wr_total;
        stall = 1'b1;
        @(negedge clk);
        op = 3'd0; cond_en = 1'b0; pc_next = 16'h0040; start = 1'b1;
        @(negedge clk);
        op = 3'd3; pair_in = 16'h9999;
        @(negedge clk);
        start = 1'b0;
        chk("R11 req held while stalled", 32'(bus_req), 32'd1);
        chk("R11 address held while stalled", 32'(bus_addr), 32'h0040);
        @(negedge clk);
        stall = 1'b0;
        @(negedge clk);
        wait_done(cyc);
        chk("R12 call pc_value", 32'(pc_value), 32'h1234);
        chk("R12 sp after ignored start", 32'(sp), 32'hFFFD);
        chk("R12 write count", 32'(wr_total - w0), 32'd2);
        @(negedge clk);
        chk("R14 idle after done", 32'(busy), 32'd0);
        chk("R12 no request after done", 32'(bus_req), 32'd0);
        launch(3'd1, 1'b0, 3'd0, 3'd0, 8'h00, 16'h0000, 16'h0000, cyc);
        chk("R5 return after stalled call", 32'(pc_value), 32'h0042);

        // R1 reset in the middle of a push
        stall = 1'b1;
        @(negedge clk);
        op = 3'd3; pair_in = 16'h1111; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 busy after mid reset", 32'(busy), 32'd0);
        chk("R1 sp after mid reset", 32'(sp), 32'hFFFF);
        chk("R1 bus_req after mid reset", 32'(bus_req), 32'd0);
        stall = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end
endmodule